// File: doc/BRIEF.md
# SDRAM Row-Open Gate and Command Encoder

This block sits between a memory controller's request queue and the command pins of a four-bank SDRAM. It takes one request at a time over a valid/ready handshake. A request is an activate, read, write or single-bank precharge, and it carries a bank number and an address field. The block tracks which banks hold an open row. It drives the matching chip-select, row-strobe, column-strobe, write-enable, bank and address pins one clock after it accepts a request.

For every bank a down-counter starts when that bank is activated. The block does not accept a read or write to that bank until the counter has run out. The counter length is the row-to-column delay divided by the clock period, rounded up, and this division is done once at elaboration. Any cycle without an accepted request puts a no-operation on the pins. This covers cycles where a column request is being stalled, so the device never sees a column command too early.

Top module: `sdram_act_gate`

## Requirements
- R1: While reset is low the pins show deselect (`sd_cs_n`, `sd_ras_n`, `sd_cas_n`, `sd_we_n` all 1), and after reset every bank is idle, so a read or write request sees `req_ready` low.
- R2: In a cycle following one with `req_valid` low, the pins carry a no-operation: `sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1.
- R3: An accepted activate (`req_op`=0) appears on the next cycle as cs/ras/cas/we = 0/0/1/1, with `sd_ba` equal to the bank and the full 11-bit row on `sd_a`.
- R4: An accepted read (`req_op`=1) appears on the next cycle as cs/ras/cas/we = 0/1/0/1, with the bank on `sd_ba`, `req_addr[7:0]` on `sd_a[7:0]`, and `sd_a[10:8]` forced to 0 whatever the upper request bits are.
- R5: An accepted write (`req_op`=2) appears as cs/ras/cas/we = 0/1/0/0, with the same bank and column placement as R4.
- R6: An accepted precharge (`req_op`=3) appears as cs/ras/cas/we = 0/0/1/0, with the bank on `sd_ba` and `sd_a[10]`=0, so that only one bank closes.
- R7: A read or write to a bank with no open row is held with `req_ready` low, and a no-operation is driven in every held cycle.
- R8: With T = ceil(TRCD_PS / CLK_PS) (5 at the defaults 18000/4000), the first read or write to a bank reaches the pins exactly T cycles after that bank's activate reached them. Once the counter has expired, a column request is accepted at once.
- R9: Banks time independently: activating one bank neither blocks column access to a bank that is already open and expired, nor shortens the new bank's T-cycle wait.
- R10: An activate to a bank that already holds an open row is held with `req_ready` low.
- R11: After a precharge, column requests to that bank are held again, and a new activate to it is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | 2 | Target bank |
| req_addr | input | 11 | Row (activate) or column in bits 7:0 (read/write) |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select pins |
| sd_a | output | 11 | Multiplexed address pins |

## Verification
The encoder is exercised with one request of each type, using row and column values whose upper bits are set. This separates correct column placement, including the forced-low bit 10, from plain pass-through of the address. The timing gate is tested three ways: a read straight after an activate, which measures the exact gap; a write to an already expired bank, which must not stall; and an activate interleaved across two banks, which shows whether each bank's counter is really independent. Held requests to closed banks, activates to open banks and access after a precharge show whether the open/idle state tracks correctly. The bank-3 case covers the top of the bank range.

// File: rtl/sdram_act_pkg.sv
// Shared request codes and pin-level command encodings for the row-open gate.
// Assumes the four command pins are ordered cs_n, ras_n, cas_n, we_n.
package sdram_act_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_DESEL = 4'b1111;
    localparam cmd_t CMD_NOP   = 4'b0111;
    localparam cmd_t CMD_ACT   = 4'b0011;
    localparam cmd_t CMD_RD    = 4'b0101;
    localparam cmd_t CMD_WR    = 4'b0100;
    localparam cmd_t CMD_PRE   = 4'b0010;

endpackage

// File: rtl/sdram_bank_timer.sv
// One bank's open flag and row-to-column countdown.
// Activate opens the bank and loads TRCD_CYC-1. The counter then falls by
// one per cycle, and column access is allowed once it is zero. Precharge
// closes the bank. Assumes the caller never asserts activate and precharge
// together.
module sdram_bank_timer #(
    parameter int TRCD_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    output logic open_o,
    output logic col_ok_o
);
    localparam int CNT_W = $clog2(TRCD_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TRCD_CYC - 1);

    logic             open_q;
    logic [CNT_W-1:0] cnt_q;

    // Track open state and count down the activate-to-column window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (act_i) begin
            open_q <= 1'b1;
            cnt_q  <= LOAD_VAL;
        end else if (pre_i) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Column access is legal once the bank is open and the window has elapsed.
    always_comb begin
        open_o   = open_q;
        col_ok_o = open_q && (cnt_q == '0);
    end
endmodule

// File: rtl/sdram_req_admit.sv
// Decides whether the request on offer may be accepted this cycle, and
// produces one-hot per-bank activate and precharge strobes for the timers.
// Purely combinational. Assumes open_i and col_ok_i come from registers.
module sdram_req_admit #(
    parameter int BANKS = 4,
    parameter int BA_W  = 2
) (
    input  logic             valid_i,
    input  logic [1:0]       op_i,
    input  logic [BA_W-1:0]  bank_i,
    input  logic [BANKS-1:0] open_i,
    input  logic [BANKS-1:0] col_ok_i,
    output logic             ready_o,
    output logic             fire_o,
    output logic [BANKS-1:0] act_o,
    output logic [BANKS-1:0] pre_o
);
    import sdram_act_pkg::*;

    // Admission rule per request type.
    always_comb begin
        case (op_e'(op_i))
            OP_ACT:  ready_o = !open_i[bank_i];
            OP_RD,
            OP_WR:   ready_o = col_ok_i[bank_i];
            default: ready_o = 1'b1;
        endcase
        fire_o = valid_i && ready_o;
    end

    // Per-bank strobes for the timers.
    for (genvar b = 0; b < BANKS; b++) begin : g_strobe
        always_comb begin
            act_o[b] = fire_o && (op_e'(op_i) == OP_ACT) && (bank_i == BA_W'(b));
            pre_o[b] = fire_o && (op_e'(op_i) == OP_PRE) && (bank_i == BA_W'(b));
        end
    end
endmodule

// File: rtl/sdram_cmd_encoder.sv
// Registers the pin-level command one cycle after acceptance.
// Drives deselect in reset and a no-operation in every cycle without an
// accepted request. Column commands keep the bits above the column low,
// which includes the auto-precharge bit.
module sdram_cmd_encoder #(
    parameter int BA_W  = 2,
    parameter int A_W   = 11,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [1:0]       op_i,
    input  logic [BA_W-1:0]  bank_i,
    input  logic [A_W-1:0]   addr_i,
    output logic             cs_n_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [BA_W-1:0]  ba_o,
    output logic [A_W-1:0]   a_o
);
    import sdram_act_pkg::*;

    cmd_t            cmd_d, cmd_q;
    logic [A_W-1:0]  a_d;

    // Select the next command and address from the accepted request.
    always_comb begin
        cmd_d = CMD_NOP;
        a_d   = '0;
        if (fire_i) begin
            case (op_e'(op_i))
                OP_ACT: begin
                    cmd_d = CMD_ACT;
                    a_d   = addr_i;
                end
                OP_RD: begin
                    cmd_d = CMD_RD;
                    a_d[COL_W-1:0] = addr_i[COL_W-1:0];
                end
                OP_WR: begin
                    cmd_d = CMD_WR;
                    a_d[COL_W-1:0] = addr_i[COL_W-1:0];
                end
                default: cmd_d = CMD_PRE;
            endcase
        end
    end

    // Pin register: deselect in reset, otherwise the selected command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_DESEL;
            ba_o  <= '0;
            a_o   <= '0;
        end else begin
            cmd_q <= cmd_d;
            ba_o  <= fire_i ? bank_i : '0;
            a_o   <= a_d;
        end
    end

    // Break the command struct out onto the individual pins.
    always_comb begin
        cs_n_o  = cmd_q.cs_n;
        ras_n_o = cmd_q.ras_n;
        cas_n_o = cmd_q.cas_n;
        we_n_o  = cmd_q.we_n;
    end
endmodule

// File: rtl/sdram_act_gate.sv
// Top: four-bank row-open gate with an activate-to-column timer per bank.
// Accepts activate/read/write/precharge requests over valid/ready and drives
// the SDRAM command pins one cycle later. Assumes TRCD_PS and CLK_PS are
// positive, and that the requester precharges a bank before re-activating it.
module sdram_act_gate #(
    parameter int BANKS   = 4,
    parameter int ROW_W   = 11,
    parameter int COL_W   = 8,
    parameter int TRCD_PS = 18000,
    parameter int CLK_PS  = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_bank,
    input  logic [10:0]      req_addr,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [1:0]       sd_ba,
    output logic [10:0]      sd_a
);
    localparam int BA_W     = $clog2(BANKS);
    localparam int TRCD_CYC = (TRCD_PS + CLK_PS - 1) / CLK_PS;

    logic [BANKS-1:0] bank_open;
    logic [BANKS-1:0] bank_col_ok;
    logic [BANKS-1:0] bank_act;
    logic [BANKS-1:0] bank_pre;
    logic             fire;

    sdram_req_admit #(
        .BANKS (BANKS),
        .BA_W  (BA_W)
    ) u_admit (
        .valid_i  (req_valid),
        .op_i     (req_op),
        .bank_i   (req_bank),
        .open_i   (bank_open),
        .col_ok_i (bank_col_ok),
        .ready_o  (req_ready),
        .fire_o   (fire),
        .act_o    (bank_act),
        .pre_o    (bank_pre)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sdram_bank_timer #(
            .TRCD_CYC (TRCD_CYC)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (bank_act[b]),
            .pre_i    (bank_pre[b]),
            .open_o   (bank_open[b]),
            .col_ok_o (bank_col_ok[b])
        );
    end

    sdram_cmd_encoder #(
        .BA_W  (BA_W),
        .A_W   (ROW_W),
        .COL_W (COL_W)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .op_i    (req_op),
        .bank_i  (req_bank),
        .addr_i  (req_addr),
        .cs_n_o  (sd_cs_n),
        .ras_n_o (sd_ras_n),
        .cas_n_o (sd_cas_n),
        .we_n_o  (sd_we_n),
        .ba_o    (sd_ba),
        .a_o     (sd_a)
    );
endmodule

// File: rtl/sdram_act_gate_chk.sv
// Property checker for sdram_act_gate. It keeps its own model of each bank's
// open state and of the cycles since activate, and checks the pins and the
// handshake against that model.
module sdram_act_gate_chk #(
    parameter int BANKS    = 4,
    parameter int BA_W     = 2,
    parameter int A_W      = 11,
    parameter int COL_W    = 8,
    parameter int TRCD_CYC = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_op,
    input logic [BA_W-1:0] req_bank,
    input logic [A_W-1:0]  req_addr,
    input logic            sd_cs_n,
    input logic            sd_ras_n,
    input logic            sd_cas_n,
    input logic            sd_we_n,
    input logic [BA_W-1:0] sd_ba,
    input logic [A_W-1:0]  sd_a
);
    import sdram_act_pkg::*;

    localparam int AGE_W = $clog2(TRCD_CYC + 1);

    logic             fire;
    logic [3:0]       pins;
    logic [BANKS-1:0] m_open;
    logic [AGE_W-1:0] m_age [BANKS];

    assign fire = req_valid && req_ready;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Shadow model: bank open flags and saturating cycles since activate.
    always_ff @(posedge clk) begin
        for (int b = 0; b < BANKS; b++) begin
            if (!rst_n) begin
                m_open[b] <= 1'b0;
                m_age[b]  <= '0;
            end else if (fire && req_bank == BA_W'(b) && req_op == OP_ACT) begin
                m_open[b] <= 1'b1;
                m_age[b]  <= '0;
            end else if (fire && req_bank == BA_W'(b) && req_op == OP_PRE) begin
                m_open[b] <= 1'b0;
            end else if (m_age[b] < AGE_W'(TRCD_CYC)) begin
                m_age[b]  <= m_age[b] + 1'b1;
            end
        end
    end

    AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> pins == 4'b0111); // R2
    AST_HOLD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> pins == 4'b0111); // R7
    AST_ACT_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_ACT |=> pins == 4'b0011 && sd_ba == $past(req_bank) && sd_a == $past(req_addr)); // R3
    AST_RD_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_RD |=> pins == 4'b0101 && sd_ba == $past(req_bank) && sd_a[COL_W-1:0] == $past(req_addr[COL_W-1:0]) && sd_a[A_W-1:COL_W] == '0); // R4
    AST_WR_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_WR |=> pins == 4'b0100 && sd_ba == $past(req_bank) && sd_a[COL_W-1:0] == $past(req_addr[COL_W-1:0]) && sd_a[A_W-1:COL_W] == '0); // R5
    AST_PRE_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_PRE |=> pins == 4'b0010 && sd_ba == $past(req_bank) && !sd_a[A_W-1]); // R6
    AST_COL_AFTER_TRCD: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (req_op == OP_RD || req_op == OP_WR) |-> m_open[req_bank] && m_age[req_bank] >= AGE_W'(TRCD_CYC - 1)); // R8
    AST_ACT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_ACT |-> !m_open[req_bank]); // R10
endmodule

bind sdram_act_gate sdram_act_gate_chk #(
    .BANKS    (BANKS),
    .BA_W     (BA_W),
    .A_W      (ROW_W),
    .COL_W    (COL_W),
    .TRCD_CYC (TRCD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_a      (sd_a)
);

// File: tb/sdram_act_gate_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sdram_act_gate_bench;
    localparam int TRCD_PS = 18000;
    localparam int CLK_PS  = 4000;
    localparam int EXP_T   = (TRCD_PS + CLK_PS - 1) / CLK_PS;

    localparam logic [3:0] P_DESEL = 4'b1111;
    localparam logic [3:0] P_NOP   = 4'b0111;
    localparam logic [3:0] P_ACT   = 4'b0011;
    localparam logic [3:0] P_RD    = 4'b0101;
    localparam logic [3:0] P_WR    = 4'b0100;
    localparam logic [3:0] P_PRE   = 4'b0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [10:0] req_addr = '0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [10:0] sd_a;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_act_gate #(.TRCD_PS(TRCD_PS), .CLK_PS(CLK_PS)) u_sdram_act_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a)
    );

    function automatic logic [3:0] pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Offer a request, count held cycles (each must show a NOP), return at
    // the negedge where the accepted command is on the pins.
    task automatic send(input string req, input logic [1:0] op, input logic [1:0] bank,
                        input logic [10:0] addr, output int waits);
        waits = 0;
        req_valid = 1'b1; req_op = op; req_bank = bank; req_addr = addr;
        #1;
        while (!req_ready && waits < 50) begin
            @(negedge clk); #1;
            waits++;
            check(req, "held cycle pins", pins(), P_NOP);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Offer a request that must stay held for n cycles, then withdraw it.
    task automatic probe_hold(input string req, input logic [1:0] op, input logic [1:0] bank, input int n);
        req_valid = 1'b1; req_op = op; req_bank = bank; req_addr = 11'h155;
        for (int i = 0; i < n; i++) begin
            #1;
            check(req, "ready while held", req_ready, 0);
            @(negedge clk);
            check(req, "pins while held", pins(), P_NOP);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "pins in reset", pins(), P_DESEL);
        req_op = 2'd1; req_bank = 2'd0; #1;
        check("R1", "read ready after reset", req_ready, 0);
        req_op = 2'd2; req_bank = 2'd3; #1;
        check("R1", "write ready after reset", req_ready, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R2", "idle pins", pins(), P_NOP);
    endtask

    task automatic t_act_then_read();
        int w; int t_act;
        send("R3", 2'd0, 2'd0, 11'h5A3, w);
        t_act = cyc;
        check("R3", "act pins", pins(), P_ACT);
        check("R3", "act ba", sd_ba, 0);
        check("R3", "act row", sd_a, 11'h5A3);
        send("R8", 2'd1, 2'd0, 11'h7C3, w);
        check("R8", "held cycles before read", w, EXP_T - 1);
        check("R8", "act-to-read gap", cyc - t_act, EXP_T);
        check("R4", "read pins", pins(), P_RD);
        check("R4", "read ba", sd_ba, 0);
        check("R4", "read column, A10..A8 low", sd_a, 11'h0C3);
    endtask

    task automatic t_write_open();
        int w;
        send("R5", 2'd2, 2'd0, 11'h681, w);
        check("R8", "no stall on expired bank", w, 0);
        check("R5", "write pins", pins(), P_WR);
        check("R5", "write column", sd_a, 11'h081);
    endtask

    task automatic t_closed_hold();
        probe_hold("R7", 2'd1, 2'd2, 6);
        @(negedge clk);
        check("R2", "pins after withdraw", pins(), P_NOP);
    endtask

    task automatic t_bank_indep();
        int w; int t_act;
        send("R9", 2'd0, 2'd1, 11'h7FF, w);
        t_act = cyc;
        check("R9", "act bank1 ba", sd_ba, 1);
        check("R9", "act bank1 row", sd_a, 11'h7FF);
        send("R9", 2'd1, 2'd0, 11'h011, w);
        check("R9", "bank0 read not stalled", w, 0);
        send("R9", 2'd1, 2'd1, 11'h022, w);
        check("R9", "bank1 act-to-read gap", cyc - t_act, EXP_T);
        check("R9", "bank1 read ba", sd_ba, 1);
    endtask

    task automatic t_act_open();
        probe_hold("R10", 2'd0, 2'd0, 4);
    endtask

    task automatic t_precharge();
        int w; int t_act;
        send("R6", 2'd3, 2'd0, 11'h7FF, w);
        check("R6", "pre pins", pins(), P_PRE);
        check("R6", "pre ba", sd_ba, 0);
        check("R6", "pre A10", sd_a[10], 0);
        probe_hold("R11", 2'd2, 2'd0, 3);
        @(negedge clk);
        send("R11", 2'd0, 2'd0, 11'h2AA, w);
        t_act = cyc;
        check("R11", "re-activate accepted at once", w, 0);
        send("R11", 2'd2, 2'd0, 11'h044, w);
        check("R11", "re-activate-to-write gap", cyc - t_act, EXP_T);
    endtask

    task automatic t_bank3();
        int w; int t_act;
        send("R3", 2'd0, 2'd3, 11'h000, w);
        t_act = cyc;
        check("R3", "bank3 act ba", sd_ba, 3);
        send("R8", 2'd2, 2'd3, 11'h0FF, w);
        check("R8", "bank3 gap", cyc - t_act, EXP_T);
        check("R5", "bank3 write column", sd_a, 11'h0FF);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_act_then_read();
        t_write_open();
        t_closed_hold();
        t_bank_indep();
        t_act_open();
        t_precharge();
        t_bank3();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule